// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Detector with Lock Monitor

This block sits in the digital half of a frequency synthesizer. It counts the reference clock down by one of three ratios (1024, 640 or 512). The ratio is fixed by a 3-bit mode input, or, in one mode, taken from a two-bit ratio field. Each terminal count of the divider is one reference edge. A phase-frequency detector compares these edges with single-cycle feedback strobes from the main divider. It drives pump-up and pump-down controls whose pulse width is the phase error in reference clock cycles.

A digital lock monitor measures every comparison. It declares lock after eight consecutive comparisons whose pulse stays within a programmable window. It drops lock at once when a pulse grows past that window. Two pump controls pass through the block: a disable, which holds both pump controls inactive so the pump floats, and a current-range select, which is passed out as a level.

The reference clock is the block clock `clk_i`. The feedback strobe is synchronous to it. A change of ratio is held off until the running count reaches its terminal value.

Top module: `refdiv_pfd_top`

## Requirements
- R1: With `ratio_sel_i` ignored, mode value 0 divides by 1024, 1 and 3 by 512, 2 by 640, and the unused values 5, 6 and 7 by 1024. The distance between consecutive rising edges of `up_o` then equals the ratio, provided feedback answers each rising edge.
- R2: In mode 4, with `ratio_sel_i[1]` as the high bit and `ratio_sel_i[0]` as the low bit, the ratio is 640 whenever the low bit is 0, 512 for high/low = 1/1, and 1024 for high/low = 0/1.
- R3: A ratio change made mid-period does not alter the running period: the period in progress completes at the old ratio, and the following one uses the new ratio.
- R4: A reference edge raises `up_o` one cycle later. It stays high until a feedback strobe is sampled, and both controls are low on the cycle after that strobe, so the up pulse width equals the feedback delay in cycles. `up_o` and `dn_o` are never high together.
- R5: A feedback strobe with no pending reference edge raises `dn_o` on the next cycle, and the following reference edge clears it without raising `up_o`.
- R6: While `pump_off_i` is 1, `up_o` and `dn_o` stay 0 and `pump_en_o` is 0; otherwise `pump_en_o` is 1.
- R7: `hi_current_o` follows `hi_current_i` (1 = high pump current range, 0 = low).
- R8: `locked_o` rises on the cycle after the eighth consecutive comparison whose pulse width is at most `lock_win_i` cycles.
- R9: `locked_o` falls on the cycle after an up or down pulse exceeds `lock_win_i` cycles, and the consecutive count restarts from zero.
- R10: During and right after reset, `up_o`, `dn_o` and `locked_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, also the block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 3 | Divider mode select |
| ratio_sel_i | input | 2 | Ratio field used in mode 4 |
| pump_off_i | input | 1 | 1 forces both pump controls inactive |
| hi_current_i | input | 1 | Pump current range select |
| lock_win_i | input | WIN_W | Largest pulse width, in cycles, counted as in-lock |
| fb_pulse_i | input | 1 | One-cycle feedback strobe from the main divider |
| up_o | output | 1 | Pump-up control |
| dn_o | output | 1 | Pump-down control |
| pump_en_o | output | 1 | 1 when the pump may drive |
| hi_current_o | output | 1 | Current range level to the pump |
| locked_o | output | 1 | Lock indication |

## Verification
The embedded properties assume that `fb_pulse_i` is a synchronous strobe and that mode and ratio inputs may change on any cycle. They need nothing about the feedback spacing. The stimulus returns a feedback strobe a bounded number of cycles after each up edge, always far below the shortest ratio, so every measured period starts from a cleared detector. Once, the stimulus injects an unsolicited strobe to exercise the down path, and once it holds the pump disabled across more than a full reference period.

// File: rtl/refpll_pkg.sv
package refpll_pkg;
  typedef enum logic [1:0] {
    RDIV_HI  = 2'd0,
    RDIV_LO  = 2'd1,
    RDIV_MID = 2'd2
  } rdiv_e;
endpackage

// File: rtl/refdiv_ratio_sel.sv
module refdiv_ratio_sel
  import refpll_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [1:0] rsel_i,
  output rdiv_e      sel_o
);
  always_comb begin
    sel_o = RDIV_HI;
    case (mode_i)
      3'd1, 3'd3: sel_o = RDIV_LO;
      3'd2:       sel_o = RDIV_MID;
      3'd4: begin
        if (!rsel_i[0])     sel_o = RDIV_MID;
        else if (rsel_i[1]) sel_o = RDIV_LO;
        else                sel_o = RDIV_HI;
      end
      default:    sel_o = RDIV_HI;
    endcase
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refpll_pkg::*;
#(
  parameter int R_HI  = 1024,
  parameter int R_LO  = 512,
  parameter int R_MID = 640
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rdiv_e sel_i,
  output logic  tick_o
);
  localparam int R_MAX = (R_HI > R_MID) ? ((R_HI > R_LO) ? R_HI : R_LO)
                                        : ((R_MID > R_LO) ? R_MID : R_LO);
  localparam int R_MIN = (R_HI < R_MID) ? ((R_HI < R_LO) ? R_HI : R_LO)
                                        : ((R_MID < R_LO) ? R_MID : R_LO);
  localparam int CNT_W = $clog2(R_MAX);
  localparam int GAP_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] LD_HI  = CNT_W'(R_HI - 1);
  localparam logic [CNT_W-1:0] LD_LO  = CNT_W'(R_LO - 1);
  localparam logic [CNT_W-1:0] LD_MID = CNT_W'(R_MID - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  always_comb begin
    case (sel_i)
      RDIV_LO:  load_val = LD_LO;
      RDIV_MID: load_val = LD_MID;
      default:  load_val = LD_HI;
    endcase
  end

  assign tick_o = (cnt_q == '0);

  // the new ratio is only sampled at terminal count
  always_comb begin
    if (tick_o) cnt_d = load_val;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // period monitor for the assertion below
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             seen_q;

  always_comb begin
    if (tick_o)                 gap_d = GAP_W'(1);
    else if (gap_q != '1)       gap_d = gap_q + GAP_W'(1);
    else                        gap_d = gap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      if (tick_o) seen_q <= 1'b1;
    end
  end

  AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> (gap_q >= GAP_W'(R_MIN))); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R1
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic fb_i,
  output logic up_q,
  output logic dn_q,
  output logic active_o,
  output logic cmp_o
);
  logic up_set, dn_set, up_d, dn_d;

  assign up_set = up_q | ref_tick_i;
  assign dn_set = dn_q | fb_i;
  assign cmp_o  = up_set & dn_set;
  assign up_d   = up_set & ~cmp_o;
  assign dn_d   = dn_set & ~cmp_o;
  assign active_o = up_q | dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  AST_PFD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q)); // R4
  AST_UP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_i && !fb_i && !dn_q) |=> up_q); // R4
  AST_DN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i && !ref_tick_i && !up_q) |=> dn_q); // R5
endmodule

// File: rtl/lock_det.sv
module lock_det #(
  parameter int WIN_W    = 8,
  parameter int LOCK_CNT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             cmp_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             locked_o
);
  localparam int GC_W = $clog2(LOCK_CNT + 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'(LOCK_CNT - 1);
  localparam logic [GC_W-1:0] GC_FULL = GC_W'(LOCK_CNT);

  logic [WIN_W-1:0] wcnt_q, wcnt_d;
  logic [GC_W-1:0]  gcnt_q, gcnt_d;
  logic             locked_q, locked_d;
  logic             good, bad;

  // width counter: cycles the current pulse has been high
  always_comb begin
    if (!active_i || cmp_i)  wcnt_d = '0;
    else if (wcnt_q != '1)   wcnt_d = wcnt_q + WIN_W'(1);
    else                     wcnt_d = wcnt_q;
  end

  assign bad  = active_i && (wcnt_q == win_i);
  assign good = cmp_i && (!active_i || (wcnt_q < win_i));

  always_comb begin
    gcnt_d   = gcnt_q;
    locked_d = locked_q;
    if (bad) begin
      gcnt_d   = '0;
      locked_d = 1'b0;
    end else if (good) begin
      if (gcnt_q != GC_FULL)  gcnt_d = gcnt_q + GC_W'(1);
      if (gcnt_q >= GC_LAST)  locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q   <= '0;
      gcnt_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      wcnt_q   <= wcnt_d;
      gcnt_q   <= gcnt_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;

  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !locked_q); // R9
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(good)); // R8
endmodule

// File: rtl/refdiv_pfd_top.sv
module refdiv_pfd_top
  import refpll_pkg::*;
#(
  parameter int R_HI     = 1024,
  parameter int R_LO     = 512,
  parameter int R_MID    = 640,
  parameter int WIN_W    = 8,
  parameter int LOCK_CNT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_sel_i,
  input  logic [1:0]       ratio_sel_i,
  input  logic             pump_off_i,
  input  logic             hi_current_i,
  input  logic [WIN_W-1:0] lock_win_i,
  input  logic             fb_pulse_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             pump_en_o,
  output logic             hi_current_o,
  output logic             locked_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  rdiv_e sel;
  logic  ref_tick, up_q, dn_q, active, cmp;

  refdiv_ratio_sel u_sel (
    .mode_i (mode_sel_i),
    .rsel_i (ratio_sel_i),
    .sel_o  (sel)
  );

  refdiv_counter #(.R_HI(R_HI), .R_LO(R_LO), .R_MID(R_MID)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .tick_o (ref_tick)
  );

  pfd_core u_pfd (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ref_tick_i (ref_tick),
    .fb_i       (fb_pulse_i),
    .up_q       (up_q),
    .dn_q       (dn_q),
    .active_o   (active),
    .cmp_o      (cmp)
  );

  lock_det #(.WIN_W(WIN_W), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .active_i (active),
    .cmp_i    (cmp),
    .win_i    (lock_win_i),
    .locked_o (locked_o)
  );

  assign pump_en_o    = ~pump_off_i;
  assign up_o         = up_q & pump_en_o;
  assign dn_o         = dn_q & pump_en_o;
  assign hi_current_o = hi_current_i;

  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(up_o && dn_o)); // R4
endmodule

// File: tb/refdiv_pfd_top_tb_top.sv
module refdiv_pfd_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] mode_sel_i;
  logic [1:0] ratio_sel_i;
  logic       pump_off_i, hi_current_i, fb_pulse_i;
  logic [7:0] lock_win_i;
  logic       up_o, dn_o, pump_en_o, hi_current_o, locked_o;

  always #2.5 clk_i = ~clk_i;

  refdiv_pfd_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_sel_i(mode_sel_i),
    .ratio_sel_i(ratio_sel_i), .pump_off_i(pump_off_i),
    .hi_current_i(hi_current_i), .lock_win_i(lock_win_i),
    .fb_pulse_i(fb_pulse_i), .up_o(up_o), .dn_o(dn_o),
    .pump_en_o(pump_en_o), .hi_current_o(hi_current_o), .locked_o(locked_o)
  );

  int  n_run = 0, n_fail = 0;
  int  cyc = 0;
  int  last_t = 0;
  int  streak = 0;
  bit  done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_ratio(logic [2:0] m, logic [1:0] r);
    case (m)
      3'd1, 3'd3: return 512;
      3'd2:       return 640;
      3'd4:       return (!r[0]) ? 640 : (r[1] ? 512 : 1024);
      default:    return 1024;
    endcase
  endfunction

  task automatic next_rise(output int t);
    while (!up_o) @(negedge clk_i);
    t = cyc;
  endtask

  // called at the negedge where up_o was just seen high
  task automatic do_cmp(int d, bit wide);
    bit exp_l;
    repeat (d - 1) @(negedge clk_i);
    chk(up_o == 1'b1 && dn_o == 1'b0, "R4 up held until feedback", up_o, 1);
    fb_pulse_i = 1'b1;
    @(negedge clk_i);
    fb_pulse_i = 1'b0;
    chk(up_o == 1'b0 && dn_o == 1'b0, "R4 cleared after feedback", {up_o, dn_o}, 0);
    if (wide || d > int'(lock_win_i)) streak = 0;
    else streak++;
    exp_l = (streak >= 8);
    chk(locked_o == exp_l, (wide || d > int'(lock_win_i)) ? "R9 lock" : "R8 lock",
        locked_o, exp_l);
    chk(hi_current_o == hi_current_i, "R7 current level", hi_current_o, hi_current_i);
    chk(pump_en_o == 1'b1, "R6 pump enabled", pump_en_o, 1);
  endtask

  task automatic step(logic [2:0] m, logic [1:0] r, int d1, int d2);
    int old_r, new_r, t1, t2, t3;
    old_r = exp_ratio(mode_sel_i, ratio_sel_i);
    mode_sel_i   = m;
    ratio_sel_i  = r;
    hi_current_i = 1'($urandom);
    new_r = exp_ratio(m, r);
    t1 = last_t;
    do_cmp(d1, 0);
    next_rise(t2);
    chk(t2 - t1 == old_r, "R3 running period kept", t2 - t1, old_r);
    do_cmp(d2, 0);
    next_rise(t3);
    chk(t3 - t2 == new_r, (m == 3'd4) ? "R2 mode-4 ratio" : "R1 fixed ratio",
        t3 - t2, new_r);
    last_t = t3;
  endtask

  initial begin
    int t;
    bit seen;
    void'($urandom(32'd1234));
    rst_ni = 1'b0;
    mode_sel_i = 3'd0; ratio_sel_i = 2'd0; pump_off_i = 1'b0;
    hi_current_i = 1'b0; fb_pulse_i = 1'b0; lock_win_i = 8'd6;
    repeat (4) @(negedge clk_i);
    chk(up_o == 0 && dn_o == 0 && locked_o == 0, "R10 reset state",
        {up_o, dn_o, locked_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(up_o == 0 && dn_o == 0 && locked_o == 0, "R10 after release",
        {up_o, dn_o, locked_o}, 0);
    next_rise(last_t);

    // directed ratios and lock build-up
    step(3'd0, 2'd0, 2, 2);
    step(3'd1, 2'd0, 1, 3);
    step(3'd2, 2'd3, 6, 2);
    step(3'd3, 2'd0, 2, 2);
    step(3'd4, 2'd1, 1, 1);
    step(3'd4, 2'd3, 2, 2);
    step(3'd4, 2'd0, 3, 3);
    step(3'd4, 2'd2, 2, 2);
    step(3'd5, 2'd1, 2, 2);
    step(3'd7, 2'd3, 2, 2);
    // R9: one pulse just past the window
    step(3'd1, 2'd0, 7, 2);

    // R5: unsolicited feedback raises dn, next reference edge clears it
    do_cmp(1, 0);
    fb_pulse_i = 1'b1;
    @(negedge clk_i);
    fb_pulse_i = 1'b0;
    chk(dn_o == 1'b1 && up_o == 1'b0, "R5 dn raised", dn_o, 1);
    seen = 0;
    repeat (600) begin
      @(negedge clk_i);
      if (up_o) seen = 1;
    end
    chk(!seen && dn_o == 1'b0, "R5 dn cleared by reference edge", {seen, dn_o}, 0);
    streak = 0;
    chk(locked_o == 1'b0, "R9 lock lost on long dn", locked_o, 0);
    next_rise(t);
    do_cmp(1, 0);
    next_rise(last_t);

    // R6: pump disabled over more than a period
    pump_off_i = 1'b1;
    seen = 0;
    repeat (1200) begin
      @(negedge clk_i);
      if (up_o || dn_o || pump_en_o) seen = 1;
    end
    chk(!seen, "R6 pump held off", seen, 0);
    pump_off_i = 1'b0;
    @(negedge clk_i);
    next_rise(t);
    do_cmp(1, 1);
    next_rise(last_t);

    // random phase
    for (int i = 0; i < 30; i++) begin
      int d1, d2;
      d1 = 1 + int'($urandom_range(0, 7));
      d2 = 1 + int'($urandom_range(0, 7));
      step(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), d1, d2);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule